// File: doc/BRIEF.md
# Float-to-Integer Truncating Converter

This block turns a floating-point value that has already been unpacked into its class, sign, unbiased exponent and significand into a signed two's-complement integer. The integer width is a parameter (32 or 64 bits). The conversion ignores any rounding mode and always truncates toward zero. Any fraction bits that are dropped are reported through an inexact flag.

Values that cannot be represented saturate and raise an invalid-conversion flag. This covers infinities, both kinds of NaN, and finite numbers whose truncated magnitude is too large. The saturation bound is asymmetric: a magnitude of exactly 2^(N-1) is accepted only when the sign is negative. A single valid strobe accompanies each operand. Exactly one clock cycle later, a registered result with its flags appears together with an output valid strobe.

Top module: `fti_convert`

## Requirements
- R1: Class code 0 (zero) gives an integer result of 0 with both flags low, whatever the sign, exponent and significand inputs.
- R2: `out_valid` equals `in_valid` from one clock earlier. While `out_valid` is low, `out_int`, `out_inexact` and `out_invalid` are all 0, including during reset.
- R3: For class code 1 (finite number), the significand has its leading 1 at bit 63 and the value is sig × 2^(exp−63). An in-range result is the integer part of that magnitude, negated in two's complement when the sign is 1.
- R4: For an in-range number, `out_inexact` is high exactly when a nonzero significand bit lies below the binary point. A negative exponent therefore gives a result of 0 with `out_inexact` high.
- R5: A class-1 value whose signed exponent is N or more saturates with `out_invalid` high.
- R6: A truncated magnitude of at least 2^(N-1) plus the sign bit saturates. As a result, −2^(N-1) converts normally, while +2^(N-1) saturates.
- R7: Class codes 2 (infinity), 3 (quiet NaN), 4 (signalling NaN) and the unused codes 5 to 7 all saturate with `out_invalid` high.
- R8: A saturated result is 2^(N-1)−1 for sign 0 and −2^(N-1) for sign 1, and `out_inexact` is low whenever `out_invalid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_class | input | 3 | Class code: 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| in_sign | input | 1 | Sign, 1 for negative |
| in_exp | input | 12 | Signed unbiased exponent |
| in_sig | input | 64 | Significand with the leading 1 at bit 63 |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_int | output | INT_W | Two's-complement integer result |
| out_inexact | output | 1 | Nonzero fraction bits were discarded |
| out_invalid | output | 1 | Result saturated (non-number or out of range) |

## Verification
Truncation with lost fraction bits and the overflow decision can both apply to the same operand. This happens with an exponent of N−1, where the magnitude reaches the saturation bound while low significand bits are still nonzero. The bench drives such operands with both signs. With sign 1 and a magnitude of exactly 2^(N-1), the result must be the most negative integer with only the inexact flag set. With sign 0, the same operand must saturate with only the invalid flag set. Random operands concentrated around exponents near −1, 0 and N are judged against a reference function that works on 65-bit unsigned arithmetic rather than on the shifter structure of the design.

// File: rtl/fti_pkg.sv
package fti_pkg;

    // Fixed operand format of the unpacked input
    localparam int SIG_W = 64;
    localparam int EXP_W = 12;

    typedef enum logic [2:0] {
        FC_ZERO = 3'd0,
        FC_NUM  = 3'd1,
        FC_INF  = 3'd2,
        FC_QNAN = 3'd3,
        FC_SNAN = 3'd4
    } fclass_e;

    typedef struct packed {
        logic                    sign;
        logic signed [EXP_W-1:0] exp;
        logic [SIG_W-1:0]        sig;
    } fnum_t;

    // Decode helpers for the class field
    function automatic logic cls_is_zero(input logic [2:0] c);
        return fclass_e'(c) == FC_ZERO;
    endfunction

    function automatic logic cls_is_num(input logic [2:0] c);
        return fclass_e'(c) == FC_NUM;
    endfunction

endpackage

// File: rtl/fti_align.sv
// Moves the integer part of the significand into the low INT_W bits
// and folds every discarded bit into a single lost-bits indication.
module fti_align
    import fti_pkg::*;
#(
    parameter int INT_W = 32
) (
    input  logic [SIG_W-1:0]        sig,
    input  logic signed [EXP_W-1:0] exp,
    output logic [INT_W-1:0]        mag,
    output logic                    lost,
    output logic                    exp_big
);
    localparam int SH_W = $clog2(SIG_W);
    localparam logic signed [EXP_W-1:0] EXP_LIM = EXP_W'(INT_W);
    localparam logic [SH_W-1:0] TOP_POS = SH_W'(SIG_W - 1);

    logic [SH_W-1:0]  sh;
    logic [SIG_W-1:0] shifted;
    logic [SIG_W-1:0] drop_mask;

    always_comb begin
        exp_big   = (exp >= EXP_LIM);
        sh        = TOP_POS - exp[SH_W-1:0];
        shifted   = sig >> sh;
        drop_mask = ~({SIG_W{1'b1}} << sh);
        if (exp < 0) begin
            mag  = '0;
            lost = |sig;
        end else if (exp_big) begin
            mag  = '0;
            lost = 1'b0;
        end else begin
            mag  = INT_W'(shifted);
            lost = |(sig & drop_mask);
        end
    end
endmodule

// File: rtl/fti_range.sv
// Asymmetric range test: magnitude must stay below 2^(INT_W-1) + sign.
module fti_range #(
    parameter int INT_W = 32
) (
    input  logic [INT_W-1:0] mag,
    input  logic             sign,
    output logic             ovf
);
    localparam logic [INT_W:0] HALF = (INT_W+1)'(1) << (INT_W - 1);

    logic [INT_W:0] bound;

    always_comb begin
        bound = HALF + (INT_W+1)'(sign);
        ovf   = ({1'b0, mag} >= bound);
    end
endmodule

// File: rtl/fti_pack.sv
// Forms the final two's-complement word, either negated magnitude or
// the saturation value selected by the sign.
module fti_pack #(
    parameter int INT_W = 32
) (
    input  logic [INT_W-1:0] mag,
    input  logic             sign,
    input  logic             sat,
    output logic [INT_W-1:0] res
);
    localparam logic [INT_W-1:0] MAX_POS = {1'b0, {(INT_W-1){1'b1}}};

    always_comb begin
        if (sat)
            res = MAX_POS + INT_W'(sign);
        else if (sign)
            res = -mag;
        else
            res = mag;
    end
endmodule

// File: rtl/fti_convert.sv
module fti_convert
    import fti_pkg::*;
#(
    parameter int INT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [2:0]       in_class,
    input  logic             in_sign,
    input  logic [11:0]      in_exp,
    input  logic [63:0]      in_sig,
    output logic             out_valid,
    output logic [INT_W-1:0] out_int,
    output logic             out_inexact,
    output logic             out_invalid
);
    fnum_t            op;
    logic [INT_W-1:0] mag;
    logic             lost;
    logic             exp_big;
    logic             mag_ovf;
    logic             is_zero;
    logic             is_num;
    logic             sat;
    logic [INT_W-1:0] packed_res;
    logic [INT_W-1:0] nxt_int;
    logic             nxt_inexact;

    always_comb begin
        op.sign = in_sign;
        op.exp  = $signed(in_exp);
        op.sig  = in_sig;
    end

    fti_align #(.INT_W(INT_W)) u_align (
        .sig     (op.sig),
        .exp     (op.exp),
        .mag     (mag),
        .lost    (lost),
        .exp_big (exp_big)
    );

    fti_range #(.INT_W(INT_W)) u_range (
        .mag  (mag),
        .sign (op.sign),
        .ovf  (mag_ovf)
    );

    fti_pack #(.INT_W(INT_W)) u_pack (
        .mag  (mag),
        .sign (op.sign),
        .sat  (sat),
        .res  (packed_res)
    );

    always_comb begin
        is_zero     = cls_is_zero(in_class);
        is_num      = cls_is_num(in_class);
        sat         = !is_zero && (!is_num || exp_big || mag_ovf);
        nxt_inexact = is_num && !sat && lost;
        nxt_int     = is_zero ? '0 : packed_res;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_int     <= '0;
            out_inexact <= 1'b0;
            out_invalid <= 1'b0;
        end else begin
            out_valid   <= in_valid;
            out_int     <= in_valid ? nxt_int : '0;
            out_inexact <= in_valid && nxt_inexact;
            out_invalid <= in_valid && sat;
        end
    end
endmodule

// File: rtl/fti_convert_chk.sv
module fti_convert_chk #(
    parameter int INT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [2:0]       in_class,
    input logic             in_sign,
    input logic             out_valid,
    input logic [INT_W-1:0] out_int,
    input logic             out_inexact,
    input logic             out_invalid
);
    localparam logic [INT_W-1:0] MAX_POS = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] MIN_NEG = {1'b1, {(INT_W-1){1'b0}}};

    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_int == '0 && !out_inexact && !out_invalid));

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid)));

    // R1
    zero_class_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(in_class) == 3'd0) |-> (out_int == '0 && !out_inexact && !out_invalid));

    // R7
    nonnum_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(in_class) >= 3'd2) |-> out_invalid);

    // R8
    sat_value_chk: assert property (@(posedge clk) disable iff (rst)
        out_invalid |-> (out_int == ($past(in_sign) ? MIN_NEG : MAX_POS)));

    // R8
    sat_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        out_invalid |-> !out_inexact);

    // R3
    pos_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_invalid && !$past(in_sign)) |-> !out_int[INT_W-1]);
endmodule

bind fti_convert fti_convert_chk #(.INT_W(INT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_class    (in_class),
    .in_sign     (in_sign),
    .out_valid   (out_valid),
    .out_int     (out_int),
    .out_inexact (out_inexact),
    .out_invalid (out_invalid)
);

// File: tb/fti_convert_test.sv
module fti_convert_test;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [2:0]   in_class = '0;
    logic         in_sign = 1'b0;
    logic [11:0]  in_exp = '0;
    logic [63:0]  in_sig = '0;
    logic         out_valid;
    logic [N-1:0] out_int;
    logic         out_inexact;
    logic         out_invalid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fti_convert #(.INT_W(N)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class),
        .in_sign(in_sign), .in_exp(in_exp), .in_sig(in_sig),
        .out_valid(out_valid), .out_int(out_int),
        .out_inexact(out_inexact), .out_invalid(out_invalid)
    );

    // Reference: {result, inexact, invalid}
    function automatic logic [N+1:0] ref_conv(input logic [2:0] c, input logic s,
                                               input int e, input logic [63:0] g);
        logic [63:0] m;
        logic        lo;
        logic [64:0] bound;
        logic [N-1:0] sat_v;
        sat_v = {1'b0, {(N-1){1'b1}}} + N'(s);
        if (c == 3'd0) return '0;
        if (c != 3'd1 || e >= N) return {sat_v, 1'b0, 1'b1};
        if (e < 0) begin
            m  = 64'd0;
            lo = (g != 64'd0);
        end else begin
            m  = g >> (63 - e);
            lo = ((g << (e + 1)) != 64'd0);
        end
        bound = (65'd1 << (N - 1)) + 65'(s);
        if ({1'b0, m} >= bound) return {sat_v, 1'b0, 1'b1};
        return {(s ? N'(-m) : N'(m)), lo, 1'b0};
    endfunction

    function automatic string pick_tag(input logic [2:0] c, input int e, input logic [N+1:0] x);
        if (c == 3'd0) return "R1";
        if (c != 3'd1) return "R7";
        if (e >= N) return "R5";
        if (x[0]) return "R6";
        if (x[1]) return "R4";
        return "R3";
    endfunction

    task automatic compare(input string tag, input logic [N+1:0] exp_v, input logic exp_vld);
        checks++;
        if (out_valid !== exp_vld || {out_int, out_inexact, out_invalid} !== exp_v) begin
            errors++;
            $display("FAIL %s: got valid=%0b int=%h inx=%0b inv=%0b, expected valid=%0b int=%h inx=%0b inv=%0b",
                     tag, out_valid, out_int, out_inexact, out_invalid,
                     exp_vld, exp_v[N+1:2], exp_v[1], exp_v[0]);
        end
    endtask

    task automatic apply(input string tag, input logic [2:0] c, input logic s,
                         input int e, input logic [63:0] g);
        logic [N+1:0] x;
        x = ref_conv(c, s, e, g);
        in_valid = 1'b1; in_class = c; in_sign = s; in_exp = 12'(e); in_sig = g;
        @(negedge clk);
        compare(tag, x, 1'b1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got no completion, expected completion");
        finish_run();
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        // R2: reset state
        compare("R2", '0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        compare("R2", '0, 1'b0);

        // R1: zero class, junk fields
        apply("R1", 3'd0, 1'b1, 40, 64'hFFFF_0000_1234_5678);
        // R3: exact values
        apply("R3", 3'd1, 1'b0, 3, 64'hA000_0000_0000_0000);
        apply("R3", 3'd1, 1'b1, 3, 64'hA000_0000_0000_0000);
        apply("R3", 3'd1, 1'b0, 0, 64'h8000_0000_0000_0000);
        // R4: discarded fraction bits
        apply("R4", 3'd1, 1'b0, 0, 64'hC000_0000_0000_0000);
        apply("R4", 3'd1, 1'b1, 0, 64'hC000_0000_0000_0000);
        apply("R4", 3'd1, 1'b0, -1, 64'h8000_0000_0000_0000);
        apply("R4", 3'd1, 1'b1, -300, 64'h8000_0000_0000_0001);
        // R5: exponent at and above N
        apply("R5", 3'd1, 1'b0, N, 64'h8000_0000_0000_0000);
        apply("R5", 3'd1, 1'b1, 63, 64'hFFFF_FFFF_FFFF_FFFF);
        // R6: asymmetric bound at exponent N-1
        apply("R6", 3'd1, 1'b1, N-1, 64'h8000_0000_0000_0000);
        apply("R6", 3'd1, 1'b0, N-1, 64'h8000_0000_0000_0000);
        apply("R6", 3'd1, 1'b1, N-1, 64'h8000_0000_8000_0000);
        apply("R6", 3'd1, 1'b1, N-1, 64'h8000_0000_4000_0000);
        apply("R6", 3'd1, 1'b0, N-2, 64'hFFFF_FFFF_FFFF_FFFF);
        // R7 / R8: non-numbers and saturation values
        apply("R7", 3'd2, 1'b0, 0, 64'd0);
        apply("R8", 3'd2, 1'b1, 0, 64'd0);
        apply("R7", 3'd3, 1'b0, 5, 64'hC000_0000_0000_0000);
        apply("R7", 3'd4, 1'b1, 5, 64'hA000_0000_0000_0000);
        apply("R7", 3'd7, 1'b0, 2, 64'h8000_0000_0000_0000);

        // R2: idle cycle with saturating data must show zeros
        in_valid = 1'b0; in_class = 3'd2; in_sign = 1'b1;
        @(negedge clk);
        compare("R2", '0, 1'b0);

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            int unsigned pick;
            logic [2:0] c;
            int e;
            logic [63:0] g;
            pick = $urandom_range(0, 19);
            c = (pick == 0) ? 3'd0 : (pick == 1) ? 3'($urandom_range(2, 7)) : 3'd1;
            pick = $urandom_range(0, 3);
            e = (pick == 0) ? $urandom_range(0, 8) - 4 :
                (pick == 1) ? $urandom_range(N - 3, N + 1) :
                $urandom_range(0, N - 1);
            g = {1'b1, 31'($urandom), 32'($urandom)};
            if ($urandom_range(0, 3) == 0) g[31:0] = '0;
            apply(pick_tag(c, e, ref_conv(c, 1'b0, e, g)), c, 1'($urandom), e, g);
            if ($urandom_range(0, 9) == 0) begin
                in_valid = 1'b0;
                @(negedge clk);
                compare("R2", '0, 1'b0);
            end
        end
        finish_run();
    end
endmodule